// File: doc/BRIEF.md
# Knob Delay-Setting Conditioner

This block turns a noisy stream of 10-bit converter readings from a delay-time knob into a steady 18-bit delay target, counted in audio samples. Each reading arrives with a one-cycle strobe. The block adds up a fixed group of readings, so the sum of the group is the new candidate delay. It raises any candidate that is too small to a floor of 0x00100 samples, which is roughly 6 ms.

The stored target moves only when the candidate is far enough from it. The block compares the two on the bits above the lowest eight, and any value it stores has bit 0 cleared. The delay slewing stage downstream reads the target. A one-cycle pulse marks the end of each group, whether or not the target moved.

Top module: `knob_delay_cond`

## Requirements
- R1: While reset is high and after it is released, `delay_tgt` reads 0x00100 and `grp_done` reads 0. The target holds that value until the first group completes.
- R2: A group is 256 strobed readings, and the candidate is their 18-bit sum. Cycles with `rdg_vld` low do not count as readings, and their `rdg_code` is ignored.
- R3: A candidate below 0x00100 is replaced by 0x00100 before it is compared or stored.
- R4: When the candidate exceeds the target by 256 or more, the target takes the candidate. A rise of 255 or less leaves the target unchanged.
- R5: A drop is measured in one's complement, which loses one LSB. The target takes the candidate only when it lies 257 or more below the target. A drop of exactly 256 is ignored.
- R6: A stored target always has bit 0 equal to 0. An odd candidate is stored minus one.
- R7: At the end of every group, the running sum and the reading count return to zero, whether or not the target was updated. A reset in the middle of a group also discards the partial sum.
- R8: `grp_done` is high for exactly one cycle, in the cycle after the clock edge that took in the group's last reading. The target update, if any, becomes visible in that same cycle.
- R9: `delay_tgt` changes only in a cycle where `grp_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdg_vld | input | 1 | Strobe: `rdg_code` holds a new reading |
| rdg_code | input | 10 | Knob converter reading |
| delay_tgt | output | 18 | Conditioned delay target in samples, always even |
| grp_done | output | 1 | One-cycle pulse at the end of each group of readings |

## Verification
Three things happen at the same clock edge when the last reading of a group arrives: the candidate is closed, the target decision is made, and the sum and counter are cleared. If the clear were handled wrongly, the last reading would be lost or would leak into the next group. The bench drives groups in back-to-back order, so every group's total is checked against the expected target. A wrong clear at that edge would show up as a wrong target in the following group. Idle cycles carrying a full-scale code are inserted in the middle of groups, and a reset is applied halfway through a group. Both prove that only strobed readings, within the current group, reach the sum.

// File: rtl/kdc_pkg.sv
package kdc_pkg;
  localparam int KDC_CODE_W    = 10;
  localparam int KDC_SUM_W     = 18;
  localparam int KDC_GROUP_N   = 256;
  localparam int KDC_FLOOR     = 'h100;
  localparam int KDC_COARSE_LSB = 8;
endpackage

// File: rtl/kdc_accum.sv
module kdc_accum #(
  parameter int CODE_W  = kdc_pkg::KDC_CODE_W,
  parameter int SUM_W   = kdc_pkg::KDC_SUM_W,
  parameter int GROUP_N = kdc_pkg::KDC_GROUP_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic [CODE_W-1:0] code,
  output logic [SUM_W-1:0]  cand,
  output logic              last
);
  localparam int CNT_W = (GROUP_N > 1) ? $clog2(GROUP_N) : 1;
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(GROUP_N - 1);

  logic [SUM_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;

  // Running total including the reading on the port this cycle
  assign cand = acc_q + SUM_W'(code);
  assign last = vld && (cnt_q == CNT_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (vld) begin
      if (last) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= cand;
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R7: group end empties both sum and count
  a_r7_group_clear: assert property (@(posedge clk) disable iff (rst)
    last |=> (acc_q == '0 && cnt_q == '0));

  // R2: idle cycles leave the partial group untouched
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !vld |=> ($stable(acc_q) && $stable(cnt_q)));
endmodule

// File: rtl/kdc_gate.sv
module kdc_gate #(
  parameter int SUM_W      = kdc_pkg::KDC_SUM_W,
  parameter int FLOOR      = kdc_pkg::KDC_FLOOR,
  parameter int COARSE_LSB = kdc_pkg::KDC_COARSE_LSB
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SUM_W-1:0] cand,
  output logic [SUM_W-1:0] tgt,
  output logic             done
);
  localparam logic [SUM_W-1:0] FLOOR_V = SUM_W'(FLOOR);

  logic [SUM_W-1:0] floored;
  logic [SUM_W:0]   diff;
  logic [SUM_W-1:0] mag;
  logic             far;
  logic [SUM_W-1:0] tgt_q;
  logic             done_q;

  always_comb begin
    floored = (cand < FLOOR_V) ? FLOOR_V : cand;
    diff    = {1'b0, floored} - {1'b0, tgt_q};
    // one's complement for a negative distance: cheap, off by one LSB
    mag     = diff[SUM_W] ? ~diff[SUM_W-1:0] : diff[SUM_W-1:0];
    far     = |mag[SUM_W-1:COARSE_LSB];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= FLOOR_V;
      done_q <= 1'b0;
    end else begin
      done_q <= load;
      if (load && far) tgt_q <= {floored[SUM_W-1:1], 1'b0};
    end
  end

  assign tgt  = tgt_q;
  assign done = done_q;

  // R3: target never sits below the floor
  a_r3_floor: assert property (@(posedge clk) disable iff (rst)
    tgt_q >= FLOOR_V);

  // R6: stored target is even
  a_r6_even: assert property (@(posedge clk) disable iff (rst)
    !tgt_q[0]);

  // R9: target moves only alongside the group pulse
  a_r9_move_with_done: assert property (@(posedge clk) disable iff (rst)
    (tgt_q != $past(tgt_q)) |-> done_q);
endmodule

// File: rtl/knob_delay_cond.sv
module knob_delay_cond #(
  parameter int CODE_W     = kdc_pkg::KDC_CODE_W,
  parameter int SUM_W      = kdc_pkg::KDC_SUM_W,
  parameter int GROUP_N    = kdc_pkg::KDC_GROUP_N,
  parameter int FLOOR      = kdc_pkg::KDC_FLOOR,
  parameter int COARSE_LSB = kdc_pkg::KDC_COARSE_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdg_vld,
  input  logic [CODE_W-1:0] rdg_code,
  output logic [SUM_W-1:0]  delay_tgt,
  output logic              grp_done
);
  logic [SUM_W-1:0] cand;
  logic             last;

  kdc_accum #(.CODE_W(CODE_W), .SUM_W(SUM_W), .GROUP_N(GROUP_N)) u_accum (
    .clk(clk), .rst(rst), .vld(rdg_vld), .code(rdg_code),
    .cand(cand), .last(last)
  );

  kdc_gate #(.SUM_W(SUM_W), .FLOOR(FLOOR), .COARSE_LSB(COARSE_LSB)) u_gate (
    .clk(clk), .rst(rst), .load(last), .cand(cand),
    .tgt(delay_tgt), .done(grp_done)
  );

  generate
    if (GROUP_N > 1) begin : g_pulse_chk
      // R8: the group pulse lasts a single cycle
      a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        grp_done |=> !grp_done);
    end
  endgenerate
endmodule

// File: tb/knob_delay_cond_test.sv
module knob_delay_cond_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdg_vld = 1'b0;
  logic [9:0]  rdg_code = '0;
  logic [17:0] delay_tgt;
  logic        grp_done;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  knob_delay_cond uut (
    .clk(clk), .rst(rst), .rdg_vld(rdg_vld), .rdg_code(rdg_code),
    .delay_tgt(delay_tgt), .grp_done(grp_done)
  );

  // {base code, extra on last reading, expected target after group}
  localparam int unsigned VEC [8][3] = '{
    '{0,    0,     'h100},   // R3: zero sum floored, no move
    '{2,    0,     'h200},   // R4: rise of exactly 256 accepted
    '{3,    'hFF,  'h3FE},   // R6: odd candidate stored even
    '{4,    'hFD,  'h3FE},   // R4: rise of 255 ignored
    '{2,    'hFE,  'h3FE},   // R5: drop of 256 ignored
    '{2,    'hFD,  'h2FC},   // R5: drop of 257 accepted
    '{1023, 0,     'h3FF00}, // R2: full-scale sum
    '{0,    'h50,  'h100}    // R3: small sum floored, moves down
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] c);
    rdg_vld = 1'b1; rdg_code = c;
    @(negedge clk);
    rdg_vld = 1'b0; rdg_code = '0;
  endtask

  task automatic group(input int base, input int extra, input logic [17:0] prev);
    for (int i = 0; i < 255; i++) begin
      push(10'(base));
      if (i == 100) begin
        rdg_code = 10'h3FF;          // R2: unstrobed code must not count
        @(negedge clk);
        rdg_code = '0;
      end
      if (i == 128) begin
        chk("R8 mid-group done", 32'(grp_done), 0);
        chk("R9 mid-group hold", 32'(delay_tgt), 32'(prev));
      end
    end
    push(10'(base + extra));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset tgt", 32'(delay_tgt), 'h100);
    chk("R1 reset done", 32'(grp_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 32'(delay_tgt), 'h100);

    for (int v = 0; v < 8; v++) begin
      logic [17:0] prev;
      prev = delay_tgt;
      group(VEC[v][0], VEC[v][1], prev);
      chk("R8 done pulse", 32'(grp_done), 1);
      chk($sformatf("R4/R5 vector %0d target", v), 32'(delay_tgt), VEC[v][2]);
      @(negedge clk);
      chk("R8 pulse ends", 32'(grp_done), 0);
    end

    // R7: reset mid-group discards the partial sum
    for (int i = 0; i < 100; i++) push(10'h3FF);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 reset mid-group", 32'(delay_tgt), 'h100);
    rst = 1'b0;
    @(negedge clk);
    group(5, 0, 18'h100);
    chk("R7 fresh group target", 32'(delay_tgt), 'h500);
    // R7: next group starts from zero after an update
    group(5, 0, 18'h500);
    chk("R7 repeat group holds", 32'(delay_tgt), 'h500);
    chk("R8 done on unchanged group", 32'(grp_done), 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule